// File: doc/BRIEF.md
# I2C Transmit Byte Queue with Serial Drain

This block sits between a register interface and the bit engine of an I2C master. Software pushes bytes into a queue by writing the data register. When the queue is enabled, the block takes the oldest byte and hands it to the bit engine one bit at a time, most significant bit first. After the eighth bit it waits for the engine to report the acknowledge slot. An ACK lets the next byte go. A NAK halts the drain at once.

After a NAK, the bytes still in the queue stay there and nothing more is sent. Software must then write the flush bit in the control register. Flushing empties the queue, clears the latched NAK and returns the drain to idle. The block also reports an empty queue, flags overflowed writes, and keeps interrupt status bits that software clears by writing 1.

The drain is a four-state machine:
- IDLE waits for a byte. It goes to SHIFT (transition "load") when the queue is enabled and not empty.
- SHIFT presents bits. It goes to WAIT_ACK (transition "last bit") when the engine consumes the final bit.
- WAIT_ACK waits for the acknowledge slot. It returns to IDLE on an ACK (transition "acked") and goes to HALT on a NAK (transition "nacked").
- HALT waits for software.
- A flush sends every state back to IDLE (transition "flush").

Top module: `i2c_txq_drain`

## Requirements
- R1: After reset:
  - the queue is empty and the drain is idle, so `bit_req` and `ack_wait` are low;
  - the FIFO status register (address 2) reads 0x14: transmit empty at bit 4, receive empty at bit 2 (always 1);
  - the interrupt status register (address 3) reads 0x00;
  - the control register (address 1) reads 0x00.
- R2: Each write to the data register (address 0) appends one byte to the queue, up to DEPTH bytes. While the enable bit (control bit 6) is 0, no byte starts transmission. A non-empty queue reads 0 at FIFO status bit 4.
- R3: Bytes leave in write order, most significant bit first. `sdo` holds the current bit while `bit_req` is high. A bit is consumed in a cycle where `bit_req` and `bit_take` are both high.
- R4: After the eighth bit is consumed, `bit_req` drops and `ack_wait` stays high until a cycle with `ack_valid` high. `ack_nak` in that cycle tells a NAK (1) from an ACK (0).
- R5: An ACK that leaves the queue empty does two things: it sets interrupt status bit 1 (transmit empty), and FIFO status bit 4 reads 1 from the next cycle.
- R6: A NAK sets interrupt status bit 0 and latches control register bit 3. Afterwards `bit_req` stays low, even with bytes still queued, until a flush.
- R7: Flush is a control write with bit 7 set. It empties the queue, clears control bit 3, returns the drain to IDLE and sets enable from bit 6 of the same write. Bit 7 always reads 0.
- R8: A data write while the queue holds DEPTH bytes is dropped and sets interrupt status bit 2. The queued bytes are unchanged.
- R9: Interrupt status bits are write-1-to-clear. Writing 0 to a bit leaves it as it was.
- R10: Clearing enable while a byte is in flight lets that byte finish, ACK slot included. The next byte does not start until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 control, 3 interrupt status |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 1 control, 2 FIFO status, 3 interrupt status |
| rd_data | output | DATA_W | Combinational read data |
| bit_req | output | 1 | A transmit bit is presented on sdo |
| sdo | output | 1 | Current transmit bit |
| bit_take | input | 1 | Bit engine consumes the presented bit |
| ack_wait | output | 1 | Waiting for the acknowledge slot |
| ack_valid | input | 1 | Acknowledge slot result is valid |
| ack_nak | input | 1 | 1 = NAK, 0 = ACK |

## Verification
The bench builds the block with DEPTH=8, so a full queue, a dropped ninth write and pointer wrap-around come up after only a few writes. With that depth it sweeps all 256 byte values through the serializer in bursts that fill the queue, and checks bit order against values it computes itself. It also covers a NAK with bytes left behind, the flush recovery, disabling during a byte, and both values of each write-1-to-clear bit.

// File: rtl/i2c_txq_pkg.sv
package i2c_txq_pkg;

    typedef enum logic [1:0] {
        SH_IDLE     = 2'd0,
        SH_SHIFT    = 2'd1,
        SH_WAIT_ACK = 2'd2,
        SH_HALT     = 2'd3
    } sh_state_e;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_FSTAT = 2'd2;
    localparam logic [1:0] ADDR_ISTAT = 2'd3;

    localparam int CTRL_FLUSH_BIT = 7;
    localparam int CTRL_EN_BIT    = 6;
    localparam int CTRL_NAK_BIT   = 3;
    localparam int FST_TXE_BIT    = 4;
    localparam int FST_RXE_BIT    = 2;
    localparam int IST_NAK_BIT    = 0;
    localparam int IST_TXE_BIT    = 1;
    localparam int IST_OVF_BIT    = 2;

endpackage

// File: rtl/i2c_txq_store.sv
module i2c_txq_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_byte,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head_byte,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_ok, pop_ok;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head_byte = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/i2c_txq_shifter.sv
module i2c_txq_shifter
    import i2c_txq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flush,
    input  logic              have_data,
    input  logic [DATA_W-1:0] head_byte,
    output logic              pop,
    output logic              bit_req,
    output logic              sdo,
    input  logic              bit_take,
    output logic              ack_wait,
    input  logic              ack_valid,
    input  logic              ack_nak,
    output logic              done_ack,
    output logic              done_nak,
    output logic              busy
);
    localparam int BCNT_W = $clog2(DATA_W);
    localparam logic [BCNT_W-1:0] TOP_BIT = BCNT_W'(DATA_W - 1);

    sh_state_e         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [BCNT_W-1:0] bcnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE: begin
                if (!flush && en && have_data) begin
                    state_nx = SH_SHIFT;               // load
                end
            end
            SH_SHIFT: begin
                if (flush) begin
                    state_nx = SH_IDLE;                // flush
                end else if (bit_take && bcnt == '0) begin
                    state_nx = SH_WAIT_ACK;            // last bit
                end
            end
            SH_WAIT_ACK: begin
                if (flush) begin
                    state_nx = SH_IDLE;
                end else if (ack_valid) begin
                    state_nx = ack_nak ? SH_HALT : SH_IDLE; // nacked / acked
                end
            end
            SH_HALT: begin
                if (flush) begin
                    state_nx = SH_IDLE;
                end
            end
            default: state_nx = SH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pop      = 1'b0;
        bit_req  = 1'b0;
        ack_wait = 1'b0;
        done_ack = 1'b0;
        done_nak = 1'b0;
        busy     = 1'b0;
        unique case (state)
            SH_IDLE: begin
                pop = !flush && en && have_data;
            end
            SH_SHIFT: begin
                bit_req = 1'b1;
                busy    = 1'b1;
            end
            SH_WAIT_ACK: begin
                ack_wait = 1'b1;
                busy     = 1'b1;
                done_ack = ack_valid && !ack_nak && !flush;
                done_nak = ack_valid && ack_nak && !flush;
            end
            SH_HALT: begin
            end
            default: begin
            end
        endcase
    end

    assign sdo = shreg[DATA_W-1];

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (pop) begin
            shreg <= head_byte;
            bcnt  <= TOP_BIT;
        end else if (state == SH_SHIFT && bit_take) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            bcnt  <= bcnt - 1'b1;
        end
    end

    a_r4_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_req && ack_wait));

    a_r6_nak_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wait && ack_valid && ack_nak && !flush) |=> (!bit_req && !ack_wait));

    a_r6_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_HALT && !flush) |=> !bit_req);

    a_r10_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en) |=> !bit_req);

    a_r3_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && !bit_take && !flush) |=> (bit_req && $stable(sdo)));

endmodule

// File: rtl/i2c_txq_regs.sv
module i2c_txq_regs
    import i2c_txq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              push,
    output logic              flush,
    output logic              en,
    input  logic              full,
    input  logic              empty,
    input  logic              busy,
    input  logic              done_ack,
    input  logic              done_nak
);
    logic en_q, nak_latch;
    logic irq_nak, irq_txe, irq_ovf;
    logic ctrl_wr, ist_wr;
    logic set_nak, set_txe, set_ovf;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign ist_wr  = wr_en && (wr_addr == ADDR_ISTAT);
    assign push    = wr_en && (wr_addr == ADDR_DATA);
    assign flush   = ctrl_wr && wr_data[CTRL_FLUSH_BIT];
    assign en      = en_q;

    assign set_nak = done_nak;
    assign set_txe = done_ack && empty;
    assign set_ovf = push && full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            nak_latch <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q <= wr_data[CTRL_EN_BIT];
            end
            if (flush) begin
                nak_latch <= 1'b0;
            end else if (done_nak) begin
                nak_latch <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_nak <= 1'b0;
            irq_txe <= 1'b0;
            irq_ovf <= 1'b0;
        end else begin
            irq_nak <= set_nak || (irq_nak && !(ist_wr && wr_data[IST_NAK_BIT]));
            irq_txe <= set_txe || (irq_txe && !(ist_wr && wr_data[IST_TXE_BIT]));
            irq_ovf <= set_ovf || (irq_ovf && !(ist_wr && wr_data[IST_OVF_BIT]));
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_EN_BIT]  = en_q;
                rd_data[CTRL_NAK_BIT] = nak_latch;
            end
            ADDR_FSTAT: begin
                rd_data[FST_TXE_BIT] = empty && !busy;
                rd_data[FST_RXE_BIT] = 1'b1;
            end
            ADDR_ISTAT: begin
                rd_data[IST_NAK_BIT] = irq_nak;
                rd_data[IST_TXE_BIT] = irq_txe;
                rd_data[IST_OVF_BIT] = irq_ovf;
            end
            default: rd_data = '0;
        endcase
    end

    a_r6_nak_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (done_nak && !flush) |=> (nak_latch && irq_nak));

    a_r7_flush_clears_nak: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !nak_latch);

    a_r8_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> irq_ovf);

endmodule

// File: rtl/i2c_txq_drain.sv
module i2c_txq_drain
    import i2c_txq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              bit_req,
    output logic              sdo,
    input  logic              bit_take,
    output logic              ack_wait,
    input  logic              ack_valid,
    input  logic              ack_nak
);
    logic              push, flush, en, full, empty, busy, pop;
    logic              done_ack, done_nak;
    logic [DATA_W-1:0] head_byte;

    i2c_txq_regs #(.DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .push     (push),
        .flush    (flush),
        .en       (en),
        .full     (full),
        .empty    (empty),
        .busy     (busy),
        .done_ack (done_ack),
        .done_nak (done_nak)
    );

    i2c_txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (wr_data),
        .pop       (pop),
        .flush     (flush),
        .head_byte (head_byte),
        .full      (full),
        .empty     (empty)
    );

    i2c_txq_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .flush     (flush),
        .have_data (!empty),
        .head_byte (head_byte),
        .pop       (pop),
        .bit_req   (bit_req),
        .sdo       (sdo),
        .bit_take  (bit_take),
        .ack_wait  (ack_wait),
        .ack_valid (ack_valid),
        .ack_nak   (ack_nak),
        .done_ack  (done_ack),
        .done_nak  (done_nak),
        .busy      (busy)
    );

endmodule

// File: tb/i2c_txq_drain_tb.sv
module i2c_txq_drain_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       bit_req, sdo, ack_wait;
    logic       bit_take = 1'b0;
    logic       ack_valid = 1'b0;
    logic       ack_nak = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_txq_drain #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .bit_req, .sdo, .bit_take, .ack_wait, .ack_valid, .ack_nak
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Bit-engine model: collect one byte MSB first, then answer the ACK slot
    task automatic recv(input logic nak, output logic [7:0] b);
        b = '0;
        bit_take = 1'b1;
        for (int i = 0; i < 8; i++) begin
            while (!bit_req) @(negedge clk);
            b = {b[6:0], sdo};
            @(negedge clk);
        end
        bit_take = 1'b0;
        while (!ack_wait) @(negedge clk);
        ack_valid = 1'b1; ack_nak = nak;
        @(negedge clk);
        ack_valid = 1'b0; ack_nak = 1'b0;
    endtask

    task automatic idle_check(input string req, input int cyc);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (bit_req) seen = 1'b1;
        end
        check(req, {7'd0, seen}, 8'h00);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, r); check("R1 fstat", r, 8'h14);
        rd(2'd3, r); check("R1 istat", r, 8'h00);
        rd(2'd1, r); check("R1 ctrl", r, 8'h00);
        check("R1 bit_req", {7'd0, bit_req}, 8'h00);

        // R2 queued while disabled: nothing sent
        wr(2'd0, 8'hA5); wr(2'd0, 8'h3C); wr(2'd0, 8'h81);
        idle_check("R2 no send while disabled", 20);
        rd(2'd2, r); check("R2 fstat not empty", r, 8'h04);

        // R3/R4/R5 drain in order
        wr(2'd1, 8'h40);
        recv(1'b0, b); check("R3 byte0", b, 8'hA5);
        recv(1'b0, b); check("R3 byte1", b, 8'h3C);
        rd(2'd3, r); check("R5 no txe while entries left", r, 8'h00);
        recv(1'b0, b); check("R3 byte2", b, 8'h81);
        rd(2'd3, r); check("R5 txe irq", r, 8'h02);
        rd(2'd2, r); check("R5 fstat empty", r, 8'h14);

        // R9 write-1-to-clear
        wr(2'd3, 8'h00); rd(2'd3, r); check("R9 zero keeps", r, 8'h02);
        wr(2'd3, 8'h02); rd(2'd3, r); check("R9 one clears", r, 8'h00);

        // R3 sweep of all byte values in full-queue bursts
        for (int blk = 0; blk < 256 / DEPTH; blk++) begin
            wr(2'd1, 8'h00);
            for (int k = 0; k < DEPTH; k++) wr(2'd0, 8'(blk * DEPTH + k));
            wr(2'd1, 8'h40);
            for (int k = 0; k < DEPTH; k++) begin
                recv(1'b0, b);
                check("R3 sweep", b, 8'(blk * DEPTH + k));
            end
        end
        rd(2'd3, r); check("R8 no overflow in sweep", r, 8'h02);
        wr(2'd3, 8'h07);

        // R8 overflow dropped
        wr(2'd1, 8'h00);
        for (int k = 0; k < DEPTH; k++) wr(2'd0, 8'(8'h50 + k));
        wr(2'd0, 8'hEE);
        rd(2'd3, r); check("R8 ovf flag", r, 8'h04);
        wr(2'd1, 8'h40);
        for (int k = 0; k < DEPTH; k++) begin
            recv(1'b0, b);
            check("R8 contents kept", b, 8'(8'h50 + k));
        end
        idle_check("R8 dropped byte not sent", 30);
        rd(2'd2, r); check("R8 empty after drain", r, 8'h14);
        wr(2'd3, 8'h07);

        // R6 NAK halts with entries left
        wr(2'd0, 8'h11); wr(2'd0, 8'h22); wr(2'd0, 8'h33);
        recv(1'b1, b); check("R6 nacked byte", b, 8'h11);
        rd(2'd3, r); check("R6 nak irq", r, 8'h01);
        rd(2'd1, r); check("R6 ctrl nak latched", r, 8'h48);
        idle_check("R6 halted", 30);
        rd(2'd2, r); check("R6 entries remain", r, 8'h04);

        // R7 flush recovery
        wr(2'd1, 8'hC0);
        rd(2'd1, r); check("R7 ctrl after flush", r, 8'h40);
        rd(2'd2, r); check("R7 fstat after flush", r, 8'h14);
        wr(2'd3, 8'h07);
        wr(2'd0, 8'h9D);
        recv(1'b0, b); check("R7 send after flush", b, 8'h9D);

        // R10 disable during a byte
        wr(2'd0, 8'h6B);
        while (!bit_req) @(negedge clk);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hC7);
        recv(1'b0, b); check("R10 in-flight byte finishes", b, 8'h6B);
        idle_check("R10 next byte held", 25);
        wr(2'd1, 8'h40);
        recv(1'b0, b); check("R10 resumes", b, 8'hC7);

        done = 1'b1;
        finish_run();
    end
endmodule